// File: doc/BRIEF.md
# Stepwise Power Mode Sequencer

This block moves a display transmitter through its ordered power states one state per step, until a requested target state is reached. The four states are one-hot codes in rising order. A step towards a lower target halves the current code. A step towards a higher target doubles it. A step away from the all-zero code goes straight to the lowest state.

Whenever a step lands in the third state, the block runs a staged release of two PLL resets. Both resets are held for a programmable number of microseconds. After that, only the second reset is held for the same time. Every other step changes only the mode code.

A walk is started with a one-cycle `start` pulse that carries the target code. The walk ends when the target is reached, or after a fixed step limit, whichever comes first. A flag marks a walk that the limit cut short. The controls are plain level and pulse pins. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode` is 4'b0001 (lowest state). `busy`, `done`, `walk_capped` and both PLL resets are low.
- R2: The code encoding is lowest=4'b0001, second=4'b0010, third=4'b0100, top=4'b1000. Each step is one clock cycle. Codes are compared as unsigned 4-bit values. A current code above the target is halved. A current code at or below the target is doubled, within 4 bits, so 4'b1000 doubled wraps to 4'b0000.
- R3: A step from code 4'b0000 towards a higher target goes directly to 4'b0001.
- R4: A start whose target equals the current `mode` raises `done` in the cycle after the start. `busy` never rises and `mode` does not change.
- R5: A step into 4'b0100 drives both PLL resets high for exactly HOLD_US*CYC_PER_US cycles. Then only `pll_b_rst` stays high for another HOLD_US*CYC_PER_US cycles. Then both are low. This applies whether the step goes up or down.
- R6: Steps into any code other than 4'b0100 leave both PLL resets low. A PLL reset is never high while `mode` is not 4'b0100.
- R7: The walk ends on the step that reaches the latched target, or on step MAX_STEPS (default 5), whichever comes first.
- R8: `busy` is high from the cycle after an accepted start until the final step and its PLL phases are over. `done` is high for exactly one cycle, in the cycle after `busy` falls, and `busy` is low while `done` is high.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The walk continues to the target latched at the accepted start.
- R10: `walk_capped` rises together with `done` when the step limit ends a walk short of its target. It is cleared at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; accepted only while not busy |
| target | input | 4 | Requested target code, latched on an accepted start |
| mode | output | 4 | Current power mode code |
| pll_a_rst | output | 1 | Reset line of the first PLL |
| pll_b_rst | output | 1 | Reset line of the second PLL |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| walk_capped | output | 1 | The last walk hit the step limit before reaching its target |

## Verification
The assertions assume that `start` and `target` are always two-state values. They do not assume that `target` is one-hot: codes such as 4'b0011 or 4'b1001 are legal, and the step rule and the step limit then decide the path. The stimulus draws targets from all 16 codes with a fixed seed. It drives inputs only at falling edges, and it pulses `start` for a single cycle. A second start is sent on purpose only while a walk is known to be running.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] MODE_LOW  = 4'b0001;
  localparam logic [CODE_W-1:0] MODE_MID  = 4'b0010;
  localparam logic [CODE_W-1:0] MODE_PLL  = 4'b0100;
  localparam logic [CODE_W-1:0] MODE_TOP  = 4'b1000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_HOLD2 = 2'd2,
    ST_HOLDB = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mode_stepper.sv
module mode_stepper
  import pwr_mode_pkg::*;
(
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] nxt
);
  always_comb begin
    if (cur > tgt)
      nxt = cur >> 1;
    else if (cur < MODE_LOW)
      nxt = MODE_LOW;
    else
      nxt = cur << 1;
  end
endmodule

// File: rtl/us_timer.sv
module us_timer #(
  parameter int CYC_PER_US = 125,
  parameter int HOLD_US    = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int UW = (HOLD_US > 1) ? $clog2(HOLD_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(HOLD_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          run_q;
  logic          us_tick;

  assign us_tick = run_q && (pre_q == PRE_LAST);
  assign expire  = us_tick && (us_q == US_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      pre_q <= '0;
      us_q  <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (us_tick) begin
        pre_q <= '0;
        if (expire) begin
          run_q <= 1'b0;
          us_q  <= '0;
        end else begin
          us_q <= us_q + UW'(1);
        end
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_mode_pkg::*;
#(
  parameter int MAX_STEPS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] next_code,
  input  logic              tmr_expire,
  output logic [CODE_W-1:0] mode,
  output logic [CODE_W-1:0] tgt_q,
  output logic              tmr_load,
  output logic              pll_a_rst,
  output logic              pll_b_rst,
  output logic              busy,
  output logic              done,
  output logic              walk_capped
);
  localparam int SW = $clog2(MAX_STEPS + 1);
  localparam logic [SW-1:0] STEP_LIMIT = SW'(MAX_STEPS);

  seq_state_t    st_q;
  logic [SW-1:0] steps_q;
  logic [SW-1:0] steps_inc;

  assign steps_inc = steps_q + SW'(1);
  assign busy      = (st_q != ST_IDLE);
  assign tmr_load  = ((st_q == ST_STEP) && (next_code == MODE_PLL)) ||
                     ((st_q == ST_HOLD2) && tmr_expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      mode        <= MODE_LOW;
      tgt_q       <= MODE_LOW;
      steps_q     <= '0;
      pll_a_rst   <= 1'b0;
      pll_b_rst   <= 1'b0;
      done        <= 1'b0;
      walk_capped <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            tgt_q       <= target;
            walk_capped <= 1'b0;
            steps_q     <= '0;
            if (target == mode) done <= 1'b1;
            else                st_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          mode    <= next_code;
          steps_q <= steps_inc;
          if (next_code == MODE_PLL) begin
            pll_a_rst <= 1'b1;
            pll_b_rst <= 1'b1;
            st_q      <= ST_HOLD2;
          end else if ((next_code == tgt_q) || (steps_inc == STEP_LIMIT)) begin
            st_q        <= ST_IDLE;
            done        <= 1'b1;
            walk_capped <= (next_code != tgt_q);
          end
        end
        ST_HOLD2: begin
          if (tmr_expire) begin
            pll_a_rst <= 1'b0;
            st_q      <= ST_HOLDB;
          end
        end
        ST_HOLDB: begin
          if (tmr_expire) begin
            pll_b_rst <= 1'b0;
            if ((mode == tgt_q) || (steps_q == STEP_LIMIT)) begin
              st_q        <= ST_IDLE;
              done        <= 1'b1;
              walk_capped <= (mode != tgt_q);
            end else begin
              st_q <= ST_STEP;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int HOLD_US    = 90,
  parameter int MAX_STEPS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] target,
  output logic [3:0] mode,
  output logic       pll_a_rst,
  output logic       pll_b_rst,
  output logic       busy,
  output logic       done,
  output logic       walk_capped
);
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] next_code;
  logic              tmr_load;
  logic              tmr_expire;

  mode_stepper u_step (
    .cur (mode),
    .tgt (tgt_q),
    .nxt (next_code)
  );

  us_timer #(
    .CYC_PER_US (CYC_PER_US),
    .HOLD_US    (HOLD_US)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .expire (tmr_expire)
  );

  seq_fsm #(
    .MAX_STEPS (MAX_STEPS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .target      (target),
    .next_code   (next_code),
    .tmr_expire  (tmr_expire),
    .mode        (mode),
    .tgt_q       (tgt_q),
    .tmr_load    (tmr_load),
    .pll_a_rst   (pll_a_rst),
    .pll_b_rst   (pll_b_rst),
    .busy        (busy),
    .done        (done),
    .walk_capped (walk_capped)
  );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int HOLD_CYC = 11250
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       pll_a_rst,
  input logic       pll_b_rst,
  input logic       busy,
  input logic       done,
  input logic       walk_capped
);
  localparam int CW = $clog2(2 * HOLD_CYC + 2) + 1;

  logic          seen_q;
  logic [CW-1:0] a_run_q;
  logic [CW-1:0] b_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      a_run_q <= '0;
      b_run_q <= '0;
    end else begin
      seen_q  <= 1'b1;
      a_run_q <= pll_a_rst ? a_run_q + CW'(1) : '0;
      b_run_q <= pll_b_rst ? b_run_q + CW'(1) : '0;
    end
  end

  p_step_rule_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (mode != $past(mode)) |->
      ((mode == ($past(mode) << 1)) || (mode == ($past(mode) >> 1)) ||
       (($past(mode) == 4'b0000) && (mode == 4'b0001))));

  p_code_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode));

  p_pll_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_a_rst |-> pll_b_rst);

  p_a_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_run_q <= CW'(HOLD_CYC));

  p_b_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    b_run_q <= CW'(2 * HOLD_CYC));

  p_pll_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_b_rst |-> (mode == 4'b0100));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_move_busy_r9: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (mode != $past(mode)) |-> $past(busy));

  p_capped_done_r10: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (walk_capped && !$past(walk_capped)) |-> done);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .HOLD_CYC (HOLD_US * CYC_PER_US)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .pll_a_rst   (pll_a_rst),
  .pll_b_rst   (pll_b_rst),
  .busy        (busy),
  .done        (done),
  .walk_capped (walk_capped)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int CPU  = 4;
  localparam int HUS  = 3;
  localparam int NHLD = CPU * HUS;
  localparam int MAXS = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] target = 4'b0001;
  logic [3:0] mode;
  logic       pll_a_rst, pll_b_rst, busy, done, walk_capped;

  int vectors = 0;
  int fails   = 0;
  logic [3:0] m_mode = 4'b0001;

  always #4 clk = ~clk;

  pwr_mode_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .MAX_STEPS(MAXS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target), .mode(mode),
    .pll_a_rst(pll_a_rst), .pll_b_rst(pll_b_rst), .busy(busy), .done(done),
    .walk_capped(walk_capped)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] next_of(input logic [3:0] c, input logic [3:0] t);
    logic [3:0] n;
    if (c > t)            n = c >> 1;
    else if (c == 4'b0000) n = 4'b0001;
    else                  n = 4'(c << 1);
    return n;
  endfunction

  task automatic model(input logic [3:0] cur, input logic [3:0] tgt,
                       output logic [3:0] fin, output int steps,
                       output int dents, output bit cap);
    logic [3:0] c = cur;
    steps = 0; dents = 0;
    if (c != tgt) begin
      do begin
        c = next_of(c, tgt);
        steps++;
        if (c == 4'b0100) dents++;
      end while (c != tgt && steps < MAXS);
    end
    fin = c;
    cap = (c != tgt);
  endtask

  task automatic run(input logic [3:0] tgt, input bit inject);
    logic [3:0] fin;
    int steps, dents, busy_c, a_c, b_c, bad_c, guard;
    bit cap;
    model(m_mode, tgt, fin, steps, dents, cap);
    @(negedge clk);
    start = 1'b1; target = tgt;
    @(negedge clk);
    start = 1'b0;
    if (inject && (steps + 2 * NHLD * dents) >= 2) begin
      start = 1'b1; target = ~tgt;
    end
    busy_c = 0; a_c = 0; b_c = 0; bad_c = 0; guard = 0;
    while (!done && guard < 2000) begin
      busy_c += int'(busy);
      a_c    += int'(pll_a_rst);
      b_c    += int'(pll_b_rst);
      if (pll_b_rst && mode != 4'b0100) bad_c++;
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    check(mode == fin, inject ? "R9 final mode" : "R7 final mode", int'(mode), int'(fin));
    if (steps == 0)
      check(busy_c == 0, "R4 no busy on equal target", busy_c, 0);
    else
      check(busy_c == steps + 2 * NHLD * dents, "R8 busy cycles", busy_c, steps + 2 * NHLD * dents);
    check(a_c == NHLD * dents, "R5 both-reset cycles", a_c, NHLD * dents);
    check(b_c == 2 * NHLD * dents, "R5 pll_b reset cycles", b_c, 2 * NHLD * dents);
    check(bad_c == 0, "R6 reset outside third state", bad_c, 0);
    check(walk_capped == cap, "R10 capped flag", int'(walk_capped), int'(cap));
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    check(pll_a_rst == 1'b0 && pll_b_rst == 1'b0, "R5 resets released",
          int'({pll_a_rst, pll_b_rst}), 0);
    m_mode = fin;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode == 4'b0001, "R1 reset mode", int'(mode), 1);
    check({busy, done, walk_capped, pll_a_rst, pll_b_rst} == 5'b0, "R1 reset outputs",
          int'({busy, done, walk_capped, pll_a_rst, pll_b_rst}), 0);
    run(4'b0001, 1'b0);           // R4 equal target
    check(mode == 4'b0001, "R4 mode unchanged", int'(mode), 1);
    run(4'b1000, 1'b0);           // R2 upward through third state
    run(4'b0001, 1'b0);           // R5 downward entry also resets
    run(4'b0011, 1'b0);           // R10 limit with oscillation
    check(mode == 4'b0010, "R7 stop at limit", int'(mode), 2);
    run(4'b1000, 1'b0);
    run(4'b0000, 1'b0);           // down to all-zero code
    check(mode == 4'b0000, "R2 reach zero", int'(mode), 0);
    run(4'b0010, 1'b0);           // R3 zero goes to lowest first
    run(4'b1000, 1'b1);           // R9 start while busy ignored
    run(4'b1001, 1'b0);           // R2 wrap of top code
    for (int i = 0; i < 40; i++) begin
      run(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule